// File: doc/BRIEF.md
# LCD Bias Toggle and Line-Count Interrupt Timer

This block drives the bias pin of an LCD panel interface and raises a periodic line-count interrupt. A single down counter counts line-clock pulses and produces a timer event once every `acbVal + 1` pulses, then reloads.

For a passive panel, each timer event flips the bias pin. This periodically reverses the panel supply polarity so that no DC offset builds up.

For an active panel, the bias pin is an output-enable strobe that follows the pixel-data-active qualifier. The timer events then feed a small down counter loaded from `apiVal`. Once that counter has seen `apiVal` events, it emits a one-cycle interrupt pulse and sets a sticky status bit, which software clears with a write-one-to-clear strobe.

Top module: `lcd_bias_timer`

## Requirements
- R1: After reset, `biasOut`, `intPulse` and `intStatus` are all 0.
- R2: While `enable` is 0:
  - `biasOut` is 0 and the bias toggle state is cleared.
  - Line-clock pulses have no effect.
  - Both counters are held at `acbVal` and `apiVal`.
  - After `enable` rises, the first timer event happens on line pulse number `acbVal + 1`.
- R3: Passive mode (`passiveMode` = 1): after n line pulses since enable, `biasOut` equals (n / (acbVal+1)) mod 2. The value is visible in the cycle after the clock edge that sampled the pulse.
- R4: Active mode (`passiveMode` = 0) with `enable` = 1: `biasOut` equals `pixActive` in the same cycle, and `acbVal` has no effect on it.
- R5: Active mode with `apiVal` = P > 0: `intPulse` is high for exactly the cycle after line pulse n when n mod (acbVal+1) = 0 and (n/(acbVal+1)) mod P = 0, and low otherwise.
- R6: With `apiVal` = 0 the interrupt counter never fires.
- R7: `intStatus` is set by every interrupt pulse and stays set until `intClr` is sampled high. When a pulse and a clear fall in the same cycle, the set wins.
- R8: In passive mode, timer events never raise `intPulse` or `intStatus`.
- R9: A new `acbVal` or `apiVal` takes effect only at the next reload of its counter, not in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable |
| passiveMode | input | 1 | 1 = passive panel, 0 = active panel |
| lineClk | input | 1 | One-cycle line-clock pulse |
| pixActive | input | 1 | High while pixel data is driven (active mode) |
| acbVal | input | CNT_W | Line pulses per timer event, minus one |
| apiVal | input | INT_W | Timer events per interrupt (0 = off) |
| intClr | input | 1 | Write-one-to-clear for the status bit |
| biasOut | output | 1 | Bias pin / output enable |
| intPulse | output | 1 | One-cycle interrupt pulse |
| intStatus | output | 1 | Sticky interrupt status |

## Verification
The bench builds the block with `CNT_W` = 4 and `INT_W` = 3. This makes every line-count setting (0 to 15) and every interrupt-count setting (0 to 7) small enough to sweep exhaustively.

In active mode, each combination runs for two full interrupt periods, so both the first interrupt and the reload-and-repeat behaviour are compared pulse by pulse against arithmetic expectations. Directed sequences cover the remaining corners: mid-count changes to either field, disabling the block during a count, and a clear that coincides with an interrupt.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  // Strobes handed from the counting control to the output datapath.
  typedef struct packed {
    logic hold;  // block disabled: clear state
    logic tick;  // line counter expired: timer event
    logic fire;  // interrupt counter expired
  } lbtStrobes_t;
endpackage

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
  import lbt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int INT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             passiveMode,
  input  logic             lineClk,
  input  logic [CNT_W-1:0] acbVal,
  input  logic [INT_W-1:0] apiVal,
  output lbtStrobes_t      strb
);
  localparam logic [CNT_W-1:0] LineZero = '0;
  localparam logic [INT_W-1:0] ApiZero  = '0;
  localparam logic [INT_W-1:0] ApiOne   = INT_W'(1);

  logic [CNT_W-1:0] lineCnt;
  logic [INT_W-1:0] apiCnt;
  logic             tick;
  logic             apiEvent;

  assign tick     = enable & lineClk & (lineCnt == LineZero);
  assign apiEvent = tick & ~passiveMode;

  assign strb.hold = ~enable;
  assign strb.tick = tick;
  assign strb.fire = apiEvent & (apiCnt == ApiOne);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
      apiCnt  <= '0;
    end else if (!enable) begin
      lineCnt <= acbVal;
      apiCnt  <= apiVal;
    end else begin
      if (lineClk) begin
        if (lineCnt == LineZero) lineCnt <= acbVal;
        else                     lineCnt <= lineCnt - 1'b1;
      end
      if (apiEvent) begin
        if (apiCnt == ApiZero || apiCnt == ApiOne) apiCnt <= apiVal;
        else                                       apiCnt <= apiCnt - 1'b1;
      end
    end
  end

  // R2: counters sit at the programmed reload values while disabled
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (lineCnt == $past(acbVal)) && (apiCnt == $past(apiVal)));

  // R9: the line counter picks up the field only at a reload
  p_reload_r9: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> lineCnt == $past(acbVal));
endmodule

// File: rtl/lbt_dp.sv
module lbt_dp
  import lbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        passiveMode,
  input  logic        pixActive,
  input  logic        intClr,
  input  lbtStrobes_t strb,
  output logic        biasOut,
  output logic        intPulse,
  output logic        intStatus
);
  logic toggleQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toggleQ   <= 1'b0;
      intPulse  <= 1'b0;
      intStatus <= 1'b0;
    end else begin
      if (strb.hold)      toggleQ <= 1'b0;
      else if (strb.tick) toggleQ <= ~toggleQ;
      intPulse  <= strb.fire;
      intStatus <= strb.fire | (intStatus & ~intClr);
    end
  end

  assign biasOut = enable & (passiveMode ? toggleQ : pixActive);

  // R3: every timer event flips the bias state
  p_toggle_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> toggleQ != $past(toggleQ));

  // R2: disabling clears the bias state
  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.hold |=> !toggleQ);

  // R7: a pulse is always accompanied by the sticky bit
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    intPulse |-> intStatus);
endmodule

// File: rtl/lcd_bias_timer.sv
module lcd_bias_timer
  import lbt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int INT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             passiveMode,
  input  logic             lineClk,
  input  logic             pixActive,
  input  logic [CNT_W-1:0] acbVal,
  input  logic [INT_W-1:0] apiVal,
  input  logic             intClr,
  output logic             biasOut,
  output logic             intPulse,
  output logic             intStatus
);
  lbtStrobes_t strb;

  lbt_ctrl #(.CNT_W(CNT_W), .INT_W(INT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .passiveMode(passiveMode),
    .lineClk(lineClk), .acbVal(acbVal), .apiVal(apiVal), .strb(strb)
  );

  lbt_dp uDp (
    .clk(clk), .rstN(rstN), .enable(enable), .passiveMode(passiveMode),
    .pixActive(pixActive), .intClr(intClr), .strb(strb),
    .biasOut(biasOut), .intPulse(intPulse), .intStatus(intStatus)
  );
endmodule

// File: tb/sim_lcd_bias_timer.sv
module sim_lcd_bias_timer;
  localparam int CNT_W = 4;
  localparam int INT_W = 3;

  logic clk = 1'b0;
  logic rstN, enable, passiveMode, lineClk, pixActive, intClr;
  logic [CNT_W-1:0] acbVal;
  logic [INT_W-1:0] apiVal;
  logic biasOut, intPulse, intStatus;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lcd_bias_timer #(.CNT_W(CNT_W), .INT_W(INT_W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .passiveMode(passiveMode),
    .lineClk(lineClk), .pixActive(pixActive), .acbVal(acbVal), .apiVal(apiVal),
    .intClr(intClr), .biasOut(biasOut), .intPulse(intPulse), .intStatus(intStatus)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic restart(input int a, input int p, input bit pas);
    @(negedge clk);
    enable = 1'b0; lineClk = 1'b0; intClr = 1'b1;
    acbVal = CNT_W'(a); apiVal = INT_W'(p); passiveMode = pas;
    @(negedge clk);
    intClr = 1'b0; enable = 1'b1;
  endtask

  // One line pulse; returns at the negedge after the sampling edge.
  task automatic pulse();
    @(negedge clk);
    lineClk = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lineClk = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; passiveMode = 1'b1; lineClk = 1'b0;
    pixActive = 1'b0; intClr = 1'b0; acbVal = '0; apiVal = '0;
    repeat (3) @(negedge clk);
    check("R1 bias", biasOut, 0);
    check("R1 pulse", intPulse, 0);
    check("R1 status", intStatus, 0);
    rstN = 1'b1;

    // R3 / R8: passive sweep, with an interrupt count that must stay silent
    for (int a = 0; a < 16; a++) begin
      restart(a, 1, 1'b1);
      for (int n = 1; n <= 40; n++) begin
        pulse();
        check("R3 passive bias", biasOut, (n / (a + 1)) % 2);
        check("R8 no passive interrupt", intPulse, 0);
      end
      check("R8 no passive status", intStatus, 0);
    end

    // R4 / R5 / R6 / R7: active sweep over every count pair
    for (int a = 0; a < 16; a++) begin
      for (int p = 0; p < 8; p++) begin
        int total;
        restart(a, p, 1'b0);
        total = 2 * (a + 1) * ((p == 0) ? 1 : p) + 1;
        for (int n = 1; n <= total; n++) begin
          int expFire;
          pixActive = n[0];
          pulse();
          expFire = (p != 0 && (n % (a + 1)) == 0 && ((n / (a + 1)) % p) == 0) ? 1 : 0;
          if (p == 0) check("R6 api zero silent", intPulse, 0);
          else        check("R5 interrupt timing", intPulse, expFire);
          check("R4 output enable", biasOut, n % 2);
        end
        @(negedge clk);
        check("R5 pulse one cycle", intPulse, 0);
        check("R7 sticky after sweep", intStatus, (p != 0) ? 1 : 0);
      end
    end
    pixActive = 1'b0;

    // R2: disable mid-count, pulses ignored, restart from a full count
    restart(2, 0, 1'b1);
    repeat (3) pulse();
    check("R2 toggled before disable", biasOut, 1);
    @(negedge clk); enable = 1'b0;
    for (int i = 0; i < 5; i++) begin
      pulse();
      check("R2 bias low while off", biasOut, 0);
    end
    @(negedge clk); enable = 1'b1;
    pulse(); check("R2 count 1", biasOut, 0);
    pulse(); check("R2 count 2", biasOut, 0);
    pulse(); check("R2 count 3 toggles", biasOut, 1);

    // R9: line field change mid-count waits for reload
    restart(3, 0, 1'b1);
    repeat (2) pulse();
    acbVal = '0;
    pulse(); check("R9 acb no early toggle", biasOut, 0);
    pulse(); check("R9 acb old count ends", biasOut, 1);
    pulse(); check("R9 acb new count", biasOut, 0);

    // R9: interrupt field change mid-count waits for reload
    restart(0, 3, 1'b0);
    pulse(); check("R9 api p1", intPulse, 0);
    apiVal = INT_W'(1);
    pulse(); check("R9 api p2", intPulse, 0);
    pulse(); check("R9 api old count fires", intPulse, 1);
    pulse(); check("R9 api new count fires", intPulse, 1);

    // R7: set beats clear, clear alone, stickiness
    restart(0, 1, 1'b0);
    @(negedge clk);
    lineClk = 1'b1; intClr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lineClk = 1'b0;
    check("R7 set wins over clear", intStatus, 1);
    @(negedge clk);
    check("R7 clear works", intStatus, 0);
    intClr = 1'b0;
    pulse();
    repeat (4) @(negedge clk);
    check("R7 stays set", intStatus, 1);
    check("R7 pulse gone", intPulse, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule